// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt lines and turns activity on them into interrupt requests. Each line has its own two-bit sense mode that picks low-level, any-change, falling-edge or rising-edge triggering. Edge and change events latch a per-line flag. A line in low-level mode never latches a flag: its request follows the sampled pin for as long as the pin stays low.

Firmware reaches an enable mask, the flags and the sense modes through a small register port. Writing a one to a flag bit clears that flag. The CPU also pulses a per-line acknowledge when it takes the vector, and that clears the flag too. A request reaches the CPU only when the line's mask bit and a global enable input are both set. The block only samples `pin_in`. A pin that firmware drives as an output therefore triggers like any other pin, which gives a way to raise a software interrupt.

Top module: `ext_irq_sense`

## Requirements
- R1: With sense code 00 (low level), `irq_req[i]` is 1 two clocks after `pin_in[i]` goes low, provided mask and enable are set. It returns to 0 two clocks after the pin goes high again.
- R2: With sense code 01 (any change), either transition of a line sets its flag. The flag is visible in the flag register two clocks after the pin changes.
- R3: With sense code 10 (falling), a high-to-low transition sets the flag and a low-to-high transition does not.
- R4: With sense code 11 (rising), a low-to-high transition sets the flag and a high-to-low transition does not.
- R5: A pulse that lasts two or more clocks always produces an event in any edge mode.
- R6: Writing 1 to a flag bit clears that flag. Writing 0 leaves the flag unchanged.
- R7: A one-clock pulse on `irq_ack[i]` clears flag i.
- R8: While a line is in sense mode 00, its flag bit stays 0 from the following clock on.
- R9: `irq_req[i]` is 1 only when, on the clock before, mask bit i and `gie` were 1 and flag i or the active low level was present. `irq_req` is registered one clock after that condition.
- R10: Reset clears mask, flags, sense modes, `irq_req`, `irq_any` and `reg_rdata`. Reset also loads the stored previous sample with the pin value, so the first clock after reset reports no edge.
- R11: If an event and a clear (write-one or acknowledge) hit the same flag in the same clock, the flag ends up set.
- R12: `irq_any` is 1 exactly when at least one bit of `irq_req` is 1.
- R13: The register map is as follows. Address 0 holds the mask. Address 1 holds the flags (write one to clear). Address 2 holds the sense modes of lines 0..3, and address 3 those of lines 4..7; line i uses bits [2i+1:2i] of its byte. `reg_rdata` shows the register selected by `reg_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | External interrupt lines |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 8 | Per-line vector-taken pulse, clears the flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| irq_req | output | 8 | Per-line gated interrupt request |
| irq_any | output | 1 | OR of all per-line requests |

## Verification
The assertions assume that all inputs hold known values once reset is released. They also assume that `pin_in`, `irq_ack` and the register strobe may change in any clock, including the clock in which an event lands on the same flag. Write-clear and acknowledge properties exclude lines with a simultaneous event, since set wins there. The bench changes every input only at the falling edge, so each value is stable over the rising edge that samples it. Random phases mix sense-mode rewrites, clears, acknowledges and pin toggles freely, and directed cases force the collision and pulse-width corners.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MASK   = 2'd0,
    ADR_FLAG   = 2'd1,
    ADR_SNS_LO = 2'd2,
    ADR_SNS_HI = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/ext_irq_sampler.sv
module ext_irq_sampler #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] pin_i,
  output logic [N_LINES-1:0] smp_o,
  output logic [N_LINES-1:0] prv_o
);

  // single sampling stage plus one history stage; both preload on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_o <= pin_i;
      prv_o <= pin_i;
    end else begin
      smp_o <= pin_i;
      prv_o <= smp_o;
    end
  end

  // R10: no edge can be seen on the first clock after reset
  p_no_false_edge_r10: assert property (@(posedge clk)
    $fell(rst) |-> (smp_o == prv_o));

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int SNS_W  = 2 * N_LINES
) (
  input  logic [SNS_W-1:0]   sense_i,
  input  logic [N_LINES-1:0] smp_i,
  input  logic [N_LINES-1:0] prv_i,
  output logic [N_LINES-1:0] evt_o,
  output logic [N_LINES-1:0] lvl_mode_o,
  output logic [N_LINES-1:0] lvl_act_o
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [1:0] md;
    logic       ev;
    assign md = sense_i[2*i +: 2];

    always_comb begin
      unique case (sense_e'(md))
        SNS_LOW:  ev = 1'b0;
        SNS_ANY:  ev = smp_i[i] ^ prv_i[i];
        SNS_FALL: ev = prv_i[i] & ~smp_i[i];
        default:  ev = ~prv_i[i] & smp_i[i];
      endcase
    end

    assign evt_o[i]      = ev;
    assign lvl_mode_o[i] = (md == SNS_LOW);
    assign lvl_act_o[i]  = (md == SNS_LOW) & ~smp_i[i];
  end

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int SNS_W  = 2 * N_LINES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N_LINES-1:0] wdata_i,
  input  logic [N_LINES-1:0] ack_i,
  input  logic [N_LINES-1:0] evt_i,
  input  logic [N_LINES-1:0] lvl_mode_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] flag_o,
  output logic [SNS_W-1:0]   sense_o,
  output logic [N_LINES-1:0] rdata_o
);

  logic [N_LINES-1:0] w1c;
  logic [N_LINES-1:0] flag_nx;

  assign w1c = (wr_i && addr_i == ADR_FLAG) ? wdata_i : '0;

  // event set has priority over both clear sources; level mode forces zero
  assign flag_nx = ((flag_o & ~w1c & ~ack_i) | evt_i) & ~lvl_mode_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o  <= '0;
      flag_o  <= '0;
      sense_o <= '0;
      rdata_o <= '0;
    end else begin
      flag_o <= flag_nx;
      if (wr_i && addr_i == ADR_MASK)   mask_o                   <= wdata_i;
      if (wr_i && addr_i == ADR_SNS_LO) sense_o[N_LINES-1:0]     <= wdata_i;
      if (wr_i && addr_i == ADR_SNS_HI) sense_o[SNS_W-1:N_LINES] <= wdata_i;
      unique case (addr_i)
        ADR_MASK:   rdata_o <= mask_o;
        ADR_FLAG:   rdata_o <= flag_o;
        ADR_SNS_LO: rdata_o <= sense_o[N_LINES-1:0];
        default:    rdata_o <= sense_o[SNS_W-1:N_LINES];
      endcase
    end
  end

  // R11 (and R2..R4): an event always leaves its flag set, even under a clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

  // R6: write-one clears flags with no concurrent event
  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == ADR_FLAG) |=> ((flag_o & $past(wdata_i & ~evt_i)) == '0));

  // R7: acknowledge clears flags with no concurrent event
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_i != '0) |=> ((flag_o & $past(ack_i & ~evt_i)) == '0));

  // R8: level-mode lines hold a zero flag
  p_level_no_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (lvl_mode_i != '0) |=> ((flag_o & $past(lvl_mode_i)) == '0));

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int SNS_W  = 2 * N_LINES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] pin_in,
  input  logic               gie,
  input  logic [N_LINES-1:0] irq_ack,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic [N_LINES-1:0] irq_req,
  output logic               irq_any
);

  logic [N_LINES-1:0] smp, prv;
  logic [N_LINES-1:0] evt, lvl_mode, lvl_act;
  logic [N_LINES-1:0] mask, flag;
  logic [SNS_W-1:0]   sense;
  logic [N_LINES-1:0] req_nx;

  ext_irq_sampler #(.N_LINES(N_LINES)) u_smp (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pin_in),
    .smp_o (smp),
    .prv_o (prv)
  );

  ext_irq_detect #(.N_LINES(N_LINES)) u_det (
    .sense_i    (sense),
    .smp_i      (smp),
    .prv_i      (prv),
    .evt_o      (evt),
    .lvl_mode_o (lvl_mode),
    .lvl_act_o  (lvl_act)
  );

  ext_irq_regs #(.N_LINES(N_LINES)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (reg_wr),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .ack_i      (irq_ack),
    .evt_i      (evt),
    .lvl_mode_i (lvl_mode),
    .mask_o     (mask),
    .flag_o     (flag),
    .sense_o    (sense),
    .rdata_o    (reg_rdata)
  );

  assign req_nx = (flag | lvl_act) & mask & {N_LINES{gie}};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= '0;
      irq_any <= 1'b0;
    end else begin
      irq_req <= req_nx;
      irq_any <= |req_nx;
    end
  end

  // R9: a request needs the enable and the mask bit on the clock before
  p_gate_enable_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_req != '0) |-> ($past(gie) && ((irq_req & ~$past(mask)) == '0)));

  // R1: an enabled low level raises its request on the next clock
  p_level_req_r1: assert property (@(posedge clk) disable iff (rst)
    ((lvl_act & mask & {N_LINES{gie}}) != '0) |=>
      ((irq_req & $past(lvl_act & mask)) == $past(lvl_act & mask)));

endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  import ext_irq_pkg::*;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] pin_in;
  logic         gie;
  logic [N-1:0] irq_ack;
  logic         reg_wr;
  logic [1:0]   reg_addr;
  logic [N-1:0] reg_wdata;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] irq_req;
  logic         irq_any;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #4 clk = ~clk;

  ext_irq_sense #(.N_LINES(N)) u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .gie(gie), .irq_ack(irq_ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_any(irq_any)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  logic [N-1:0]   m_s, m_p, m_flag, m_mask, m_req, m_rdata;
  logic [2*N-1:0] m_sense;
  logic           m_any;
  logic [N-1:0]   t_ev, t_lm, t_la, t_clr, t_req;

  function automatic logic [N-1:0] f_evt(input logic [2*N-1:0] sn,
                                         input logic [N-1:0] s, input logic [N-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (sn[2*i +: 2])
        2'b00:   r[i] = 1'b0;
        2'b01:   r[i] = s[i] != p[i];
        2'b10:   r[i] = p[i] && !s[i];
        default: r[i] = !p[i] && s[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [N-1:0] f_lvl(input logic [2*N-1:0] sn);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (sn[2*i +: 2] == 2'b00);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s <= pin_in; m_p <= pin_in; m_flag <= '0; m_mask <= '0;
      m_sense <= '0; m_req <= '0; m_any <= 1'b0; m_rdata <= '0;
    end else begin
      t_ev  = f_evt(m_sense, m_s, m_p);
      t_lm  = f_lvl(m_sense);
      t_la  = t_lm & ~m_s;
      t_clr = ((reg_wr && reg_addr == 2'd1) ? reg_wdata : '0) | irq_ack;
      t_req = (m_flag | t_la) & m_mask & {N{gie}};
      m_flag <= ((m_flag & ~t_clr) | t_ev) & ~t_lm;
      m_s <= pin_in;
      m_p <= m_s;
      m_req <= t_req;
      m_any <= |t_req;
      case (reg_addr)
        2'd0: m_rdata <= m_mask;
        2'd1: m_rdata <= m_flag;
        2'd2: m_rdata <= m_sense[N-1:0];
        default: m_rdata <= m_sense[2*N-1:N];
      endcase
      if (reg_wr && reg_addr == 2'd0) m_mask <= reg_wdata;
      if (reg_wr && reg_addr == 2'd2) m_sense[N-1:0] <= reg_wdata;
      if (reg_wr && reg_addr == 2'd3) m_sense[2*N-1:N] <= reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_req,   m_req,   "R9 model irq_req");
      chk(irq_any,   m_any,   "R12 model irq_any");
      chk(reg_rdata, m_rdata, "R13 model reg_rdata");
    end
  end

  // ---------------- directed helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [N-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a;
    step(1);
    d = reg_rdata;
  endtask

  initial begin : wdog
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] rd;
    int unsigned seed;
    seed = $urandom(32'h5eed);
    pin_in = 8'hFF; gie = 1'b0; irq_ack = '0; reg_wr = 1'b0;
    reg_addr = 2'd0; reg_wdata = '0; rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    chk(irq_req, 8'h00, "R10 reset irq_req");
    chk(irq_any, 1'b0, "R10 reset irq_any");
    rreg(2'd0, rd); chk(rd, 8'h00, "R10 reset mask");
    rreg(2'd1, rd); chk(rd, 8'h00, "R10 reset flags");
    rreg(2'd3, rd); chk(rd, 8'h00, "R10 reset sense");

    // all lines any-change, pins held high: no event
    wreg(2'd2, 8'h55); wreg(2'd3, 8'h55);
    step(4);
    rreg(2'd1, rd); chk(rd, 8'h00, "R10 no false edge");
    rreg(2'd2, rd); chk(rd, 8'h55, "R13 sense lo readback");

    // R2 any change on line 0
    pin_in = 8'hFE; step(3);
    rreg(2'd1, rd); chk(rd, 8'h01, "R2 change sets flag");
    gie = 1'b1; wreg(2'd0, 8'hFF); step(1);
    chk(irq_req, 8'h01, "R9 flag request");
    chk(irq_any, 1'b1, "R12 any request");

    // R6 write-one-to-clear
    wreg(2'd1, 8'h00); rreg(2'd1, rd); chk(rd, 8'h01, "R6 write zero keeps");
    wreg(2'd1, 8'h01); rreg(2'd1, rd); chk(rd, 8'h00, "R6 write one clears");

    // R3 falling on line 1 (bits 3:2 = 10)
    wreg(2'd2, 8'h59);
    pin_in = 8'hFC; step(3);
    rreg(2'd1, rd); chk(rd, 8'h02, "R3 falling sets");
    wreg(2'd1, 8'h02);
    pin_in = 8'hFE; step(3);
    rreg(2'd1, rd); chk(rd, 8'h00, "R3 rising ignored");

    // R4 rising on line 2 (bits 5:4 = 11)
    wreg(2'd2, 8'h79);
    pin_in = 8'hFA; step(3);
    rreg(2'd1, rd); chk(rd, 8'h00, "R4 falling ignored");
    pin_in = 8'hFE; step(3);
    rreg(2'd1, rd); chk(rd, 8'h04, "R4 rising sets");

    // R7 acknowledge
    irq_ack = 8'h04; step(1); irq_ack = '0;
    rreg(2'd1, rd); chk(rd, 8'h00, "R7 ack clears");

    // R11 set and clear in the same clock on line 3
    pin_in = 8'hF6; step(1);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h08;
    step(1);
    reg_wr = 1'b0;
    rreg(2'd1, rd); chk(rd, 8'h08, "R11 set beats clear");
    wreg(2'd1, 8'h08);

    // R1/R8 level on line 4 (hi byte bits 1:0 = 00)
    wreg(2'd3, 8'h54);
    pin_in = 8'hE6; step(2);
    chk(irq_req, 8'h10, "R1 low level requests");
    chk(irq_any, 1'b1, "R12 level any");
    rreg(2'd1, rd); chk(rd, 8'h00, "R8 level flag zero");
    pin_in = 8'hF6; step(2);
    chk(irq_req, 8'h00, "R1 high level drops");

    // R9 gating
    pin_in = 8'hE6; gie = 1'b0; step(2);
    chk(irq_req, 8'h00, "R9 global disable");
    gie = 1'b1; step(2);
    chk(irq_req, 8'h10, "R9 global enable");
    wreg(2'd0, 8'hEF); step(1);
    chk(irq_req, 8'h00, "R9 mask off");
    chk(irq_any, 1'b0, "R12 none");
    wreg(2'd0, 8'hFF);

    // R5 two-clock pulse on line 5, falling mode (hi bits 3:2 = 10)
    wreg(2'd3, 8'h58);
    pin_in = 8'hC6; step(2);
    pin_in = 8'hE6; step(3);
    rreg(2'd1, rd); chk(rd, 8'h20, "R5 short pulse caught");
    wreg(2'd1, 8'h20);

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      pin_in    = pin_in ^ (N'($urandom) & N'($urandom) & N'($urandom));
      gie       = ($urandom % 8) != 0;
      irq_ack   = (($urandom % 6) == 0) ? N'($urandom) : '0;
      reg_wr    = ($urandom % 5) == 0;
      reg_addr  = 2'($urandom);
      reg_wdata = N'($urandom);
      step(1);
    end
    reg_wr = 1'b0; irq_ack = '0;
    step(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule